// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block keeps an asynchronous DRAM alive. It sits between the access sequencer and the DRAM strobe pins. After reset it waits out a start-up pause. It then runs a fixed number of wake-up cycles. After that it raises a periodic refresh demand, arbitrates that demand against host traffic, and drives the refresh strobes once the sequencer hands over the pins. Refresh cycles take one of two forms. In the counter style, CAS drops first and the device's own row counter selects the row. In the row-address style, CAS stays high and the block presents its own wrapping row counter on the address pins.

The sequencer reports an open page with `page_open` and gives up the pins with `grant`. The block asks for the pins with `ref_req`. It raises `ready` only when the host may start a new access. Refresh demands that arrive while a page is open are stored up to a limit and then run back to back. If the device sees no strobe activity for a long time, the wake-up cycles run again. An optional self-refresh request parks the device with RAS held low. The 4096-row and 2048-row variants differ only in `ROW_BITS` (12 or 11) and in the interval parameter, which works out to the same period per row.

Top module: `dram_refresh_sched`

## Requirements
- R1: For `PAUSE_CYC` cycles after reset is released, `ras_n` and `cas_n` stay high and `ref_req` and `ready` stay low.
- R2: After the pause, exactly `INIT_CYCLES` refresh cycles run before `ready` first rises. Each uses the counter style when `ras_only_mode`=0 and the row-address style when it is 1.
- R3: In a counter-style cycle, `cas_n` is low for at least `CBR_LEAD_CYC` cycles before `ras_n` falls and stays low for as long as `ras_n` is low. In every cycle, `ras_n` stays low for at least `RAS_LOW_CYC` cycles and high for at least `PRECH_CYC` cycles between pulses.
- R4: Once initialised, one refresh demand arises every `REF_INTERVAL_CYC` cycles. When the pins are granted, each demand yields one RAS pulse.
- R5: While `page_open` is high, no refresh cycle starts. Up to `MAX_POSTPONE` demands are kept and further ones are dropped. The kept demands run back to back once the page closes.
- R6: A strobe sequence starts only while `grant`=1 and `page_open`=0. `ready` is low whenever a refresh is owed or a strobe sequence is running. `ref_req` is high while one is owed.
- R7: In a row-address cycle, `cas_n` stays high. `row_addr` advances by one after each such cycle and wraps to 0 after row 2^`ROW_BITS`-1.
- R8: If, after initialisation, `page_open` is low and the block drives no strobes for `IDLE_LIMIT_CYC` cycles, `ready` drops. `INIT_CYCLES` wake-up cycles then run again, with no pause, before `ready` returns.
- R9: With `selfref_req`=1 and the pins granted, the block enters self-refresh: CAS first, then RAS. RAS stays low for at least `SR_MIN_CYC` cycles and for as long as the request stays high. RAS then stays high for at least `SR_PRECH_CYC` cycles before the next fall.
- R10: During reset, `ras_n`=1, `cas_n`=1, `ready`=0, `ref_req`=0 and `row_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_only_mode | input | 1 | 1 selects row-address refresh, 0 the counter style; change only while `ready`=1 |
| page_open | input | 1 | Sequencer has a page open or an access in flight |
| grant | input | 1 | Sequencer releases the strobe pins to this block |
| selfref_req | input | 1 | Request to park the device in self-refresh |
| ref_req | output | 1 | Block needs the pins |
| ready | output | 1 | Host may start a new access |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | ROW_BITS | Row address for row-address refresh |

## Verification
The bench builds the block with `ROW_BITS`=3, `PAUSE_CYC`=50, `REF_INTERVAL_CYC`=100, `IDLE_LIMIT_CYC`=400 and `SR_MIN_CYC`=20. The strobe widths keep their default cycle counts. With these values the row counter wraps after eight row-address cycles, and several refresh intervals fit in a thousand cycles. Both the idle-triggered re-initialisation and the minimum self-refresh hold are therefore reached in a short run. At these sizes the postponement cap can also be overrun, and the wake-up count can be told apart from a burst of postponed refreshes.

// File: rtl/dram_ref_pkg.sv
// Shared types for the DRAM refresh scheduler.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_ref_pkg;

    // Strobe engine states
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_LEAD,
        ENG_RASLO,
        ENG_PRE,
        ENG_SR_LEAD,
        ENG_SR_HOLD,
        ENG_SR_PRE
    } eng_state_e;

    // Power-up sequencing states
    typedef enum logic [1:0] {
        INI_PAUSE,
        INI_RUN,
        INI_DONE
    } init_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_ref_init.sv
// Power-up and idle re-initialisation sequencer.
// Waits PAUSE_CYC cycles after reset, then asks for INIT_CYCLES refresh cycles.
// Once done, it watches for a stretch of IDLE_LIMIT_CYC cycles without
// activity and then asks for the wake-up cycles again, with no pause.
// Assumes: cyc_done pulses once per finished refresh cycle.
module dram_ref_init #(
    parameter int unsigned PAUSE_CYC      = 20000,
    parameter int unsigned INIT_CYCLES    = 8,
    parameter int unsigned IDLE_LIMIT_CYC = 800000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_done,
    input  logic activity,
    output logic in_pause,
    output logic in_run,
    output logic done
);
    import dram_ref_pkg::*;

    localparam int unsigned PW = $clog2(PAUSE_CYC + 1);
    localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
    localparam int unsigned DW = $clog2(IDLE_LIMIT_CYC + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
    localparam logic [IW-1:0] INIT_LOAD  = IW'(INIT_CYCLES);
    localparam logic [DW-1:0] IDLE_LAST  = DW'(IDLE_LIMIT_CYC - 1);

    init_state_e     state;
    logic [PW-1:0]   pcnt;
    logic [IW-1:0]   icnt;
    logic [DW-1:0]   idle_cnt;

    // Sequence pause, wake-up cycles and idle watchdog
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= INI_PAUSE;
            pcnt     <= '0;
            icnt     <= '0;
            idle_cnt <= '0;
        end else begin
            case (state)
                INI_PAUSE: begin
                    if (pcnt == PAUSE_LAST) begin
                        state <= INI_RUN;
                        icnt  <= INIT_LOAD;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                INI_RUN: begin
                    if (cyc_done) begin
                        if (icnt == IW'(1)) begin
                            state    <= INI_DONE;
                            idle_cnt <= '0;
                        end
                        icnt <= icnt - 1'b1;
                    end
                end
                INI_DONE: begin
                    if (activity) begin
                        idle_cnt <= '0;
                    end else if (idle_cnt == IDLE_LAST) begin
                        state    <= INI_RUN;
                        icnt     <= INIT_LOAD;
                        idle_cnt <= '0;
                    end else begin
                        idle_cnt <= idle_cnt + 1'b1;
                    end
                end
                default: state <= INI_PAUSE;
            endcase
        end
    end

    assign in_pause = (state == INI_PAUSE);
    assign in_run   = (state == INI_RUN);
    assign done     = (state == INI_DONE);

    // R2: completion is only reached through the wake-up phase
    a_r2_done_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(in_run));

    // R8: the idle counter never passes its limit while initialised
    a_r8_idle_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (idle_cnt <= IDLE_LAST));

endmodule

// File: rtl/dram_ref_timer.sv
// Refresh interval timer with a saturating store of postponed demands.
// Runs only while run=1; clears both counters otherwise.
// Assumes: ref_done pulses once per finished refresh cycle.
module dram_ref_timer #(
    parameter int unsigned REF_INTERVAL_CYC = 1562,
    parameter int unsigned MAX_POSTPONE     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_done,
    output logic pending_nz
);
    localparam int unsigned TW = $clog2(REF_INTERVAL_CYC + 1);
    localparam int unsigned QW = $clog2(MAX_POSTPONE + 1);
    localparam logic [TW-1:0] T_LAST = TW'(REF_INTERVAL_CYC - 1);
    localparam logic [QW-1:0] Q_MAX  = QW'(MAX_POSTPONE);

    logic [TW-1:0] tcnt;
    logic [QW-1:0] pending;
    logic          tick;

    assign tick = (tcnt == T_LAST);

    // Count the interval and keep the number of owed refreshes
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tcnt    <= '0;
            pending <= '0;
        end else begin
            tcnt <= tick ? '0 : tcnt + 1'b1;
            case ({tick, ref_done})
                2'b10:   if (pending != Q_MAX) pending <= pending + 1'b1;
                2'b01:   if (pending != '0)    pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
        end
    end

    assign pending_nz = (pending != '0);

    // R5: stored demands never exceed the cap
    a_r5_pending_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= Q_MAX);

    // R5: the store moves by one step at a time, or is cleared
    a_r5_pending_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pending) |-> (pending == $past(pending) + 1'b1 ||
                               pending == $past(pending) - 1'b1 ||
                               pending == '0));

endmodule

// File: rtl/dram_ref_engine.sv
// Strobe engine: drives one refresh cycle (counter or row-address style)
// or a self-refresh stay, counting each phase in clock cycles.
// Assumes: go_ref and go_sr are only raised while idle=1 and never together.
module dram_ref_engine #(
    parameter int unsigned ROW_BITS     = 12,
    parameter int unsigned CBR_LEAD_CYC = 1,
    parameter int unsigned RAS_LOW_CYC  = 5,
    parameter int unsigned PRECH_CYC    = 3,
    parameter int unsigned SR_MIN_CYC   = 10000,
    parameter int unsigned SR_PRECH_CYC = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_ref,
    input  logic                go_sr,
    input  logic                ras_only,
    input  logic                sr_hold_req,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] row_addr,
    output logic                idle,
    output logic                ref_done
);
    import dram_ref_pkg::*;

    localparam int unsigned CMAX = max_of(max_of(CBR_LEAD_CYC, RAS_LOW_CYC),
                                          max_of(max_of(PRECH_CYC, SR_MIN_CYC), SR_PRECH_CYC));
    localparam int unsigned CW = $clog2(CMAX + 1);
    localparam int unsigned RW = CW + 1;
    localparam logic [CW-1:0] LEAD_LOAD  = CW'(CBR_LEAD_CYC - 1);
    localparam logic [CW-1:0] LOW_LOAD   = CW'(RAS_LOW_CYC - 1);
    localparam logic [CW-1:0] PRE_LOAD   = CW'(PRECH_CYC - 1);
    localparam logic [CW-1:0] SRMIN_LOAD = CW'(SR_MIN_CYC - 1);
    localparam logic [CW-1:0] SRPRE_LOAD = CW'(SR_PRECH_CYC - 1);

    eng_state_e          state;
    logic [CW-1:0]       cnt;
    logic                ro_kind;
    logic [ROW_BITS-1:0] row;
    logic                ras_low;
    logic                cas_low;
    logic [RW-1:0]       low_run;

    // Walk the strobe phases and advance the row counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ENG_IDLE;
            cnt     <= '0;
            ro_kind <= 1'b0;
            row     <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (go_ref) begin
                        ro_kind <= ras_only;
                        state   <= ras_only ? ENG_RASLO : ENG_LEAD;
                        cnt     <= ras_only ? LOW_LOAD : LEAD_LOAD;
                    end else if (go_sr) begin
                        ro_kind <= 1'b0;
                        state   <= ENG_SR_LEAD;
                        cnt     <= LEAD_LOAD;
                    end
                end
                ENG_LEAD: begin
                    if (cnt == '0) begin
                        state <= ENG_RASLO;
                        cnt   <= LOW_LOAD;
                    end else cnt <= cnt - 1'b1;
                end
                ENG_RASLO: begin
                    if (cnt == '0) begin
                        state <= ENG_PRE;
                        cnt   <= PRE_LOAD;
                    end else cnt <= cnt - 1'b1;
                end
                ENG_PRE: begin
                    if (cnt == '0) begin
                        state <= ENG_IDLE;
                        if (ro_kind) row <= row + 1'b1;
                    end else cnt <= cnt - 1'b1;
                end
                ENG_SR_LEAD: begin
                    if (cnt == '0) begin
                        state <= ENG_SR_HOLD;
                        cnt   <= SRMIN_LOAD;
                    end else cnt <= cnt - 1'b1;
                end
                ENG_SR_HOLD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else if (!sr_hold_req) begin
                        state <= ENG_SR_PRE;
                        cnt   <= SRPRE_LOAD;
                    end
                end
                ENG_SR_PRE: begin
                    if (cnt == '0) state <= ENG_IDLE;
                    else cnt <= cnt - 1'b1;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // Decode strobe levels from the phase
    always_comb begin
        ras_low = (state == ENG_RASLO) || (state == ENG_SR_HOLD);
        cas_low = (state == ENG_LEAD) || (state == ENG_SR_LEAD) ||
                  (state == ENG_SR_HOLD) || (state == ENG_RASLO && !ro_kind);
    end

    assign ras_n    = !ras_low;
    assign cas_n    = !cas_low;
    assign row_addr = row;
    assign idle     = (state == ENG_IDLE);
    assign ref_done = (state == ENG_PRE) && (cnt == '0);

    // Checker: length of the current RAS-low run, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)          low_run <= '0;
        else if (!ras_n)     low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
        else                 low_run <= '0;
    end

    // R3: CAS is already low in the cycle before a counter-style RAS fall
    a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

    // R3: every RAS pulse meets the minimum low width
    a_r3_ras_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run >= RW'(RAS_LOW_CYC)));

    // R9: a self-refresh stay lasts at least the minimum hold
    a_r9_sr_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && state == ENG_SR_PRE) |-> (low_run >= RW'(SR_MIN_CYC)));

    // R7: the row address only ever steps by one
    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_addr) |-> (row_addr == $past(row_addr) + 1'b1));

endmodule

// File: rtl/dram_refresh_sched.sv
// DRAM refresh and power-up scheduler (top).
// Sequences the start-up pause and wake-up cycles, times periodic refresh,
// arbitrates against the host through page_open/grant and drives the strobes.
// Assumes: the sequencer holds grant while ref_req is high once it has closed
// its page, and keeps page_open low while this block drives the strobes.
module dram_refresh_sched #(
    parameter int unsigned ROW_BITS         = 12,
    parameter int unsigned PAUSE_CYC        = 20000,
    parameter int unsigned INIT_CYCLES      = 8,
    parameter int unsigned REF_INTERVAL_CYC = 1562,
    parameter int unsigned IDLE_LIMIT_CYC   = 800000,
    parameter int unsigned MAX_POSTPONE     = 4,
    parameter int unsigned CBR_LEAD_CYC     = 1,
    parameter int unsigned RAS_LOW_CYC      = 5,
    parameter int unsigned PRECH_CYC        = 3,
    parameter int unsigned SR_MIN_CYC       = 10000,
    parameter int unsigned SR_PRECH_CYC     = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_only_mode,
    input  logic                page_open,
    input  logic                grant,
    input  logic                selfref_req,
    output logic                ref_req,
    output logic                ready,
    output logic                ras_n,
    output logic                cas_n,
    output logic [ROW_BITS-1:0] row_addr
);
    logic in_pause, in_run, init_done;
    logic pend_nz;
    logic eng_idle, ref_done;
    logic pins_free, go_ref, go_sr, activity;

    // Arbitration between owed refresh, self-refresh and the host
    always_comb begin
        pins_free = eng_idle && grant && !page_open;
        go_ref    = pins_free && (in_run || (init_done && pend_nz));
        go_sr     = pins_free && init_done && !pend_nz && selfref_req;
        activity  = page_open || !eng_idle;
        ref_req   = in_run || (init_done && (pend_nz || selfref_req)) || !eng_idle;
        ready     = init_done && eng_idle && !pend_nz;
    end

    dram_ref_init #(
        .PAUSE_CYC      (PAUSE_CYC),
        .INIT_CYCLES    (INIT_CYCLES),
        .IDLE_LIMIT_CYC (IDLE_LIMIT_CYC)
    ) u_init (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_done (ref_done && in_run),
        .activity (activity),
        .in_pause (in_pause),
        .in_run   (in_run),
        .done     (init_done)
    );

    dram_ref_timer #(
        .REF_INTERVAL_CYC (REF_INTERVAL_CYC),
        .MAX_POSTPONE     (MAX_POSTPONE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (init_done),
        .ref_done   (ref_done && init_done),
        .pending_nz (pend_nz)
    );

    dram_ref_engine #(
        .ROW_BITS     (ROW_BITS),
        .CBR_LEAD_CYC (CBR_LEAD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECH_CYC    (PRECH_CYC),
        .SR_MIN_CYC   (SR_MIN_CYC),
        .SR_PRECH_CYC (SR_PRECH_CYC)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_ref      (go_ref),
        .go_sr       (go_sr),
        .ras_only    (ras_only_mode),
        .sr_hold_req (selfref_req),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .row_addr    (row_addr),
        .idle        (eng_idle),
        .ref_done    (ref_done)
    );

    // R1: the start-up pause is silent on the pins and the request
    a_r1_pause_silent: assert property (@(posedge clk) disable iff (!rst_n)
        in_pause |-> (ras_n && cas_n && !ref_req && !ready));

    // R6: the host is never told ready while strobes are active
    a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ras_n && cas_n));

    // R6: a new strobe sequence begins only on a granted, closed page
    a_r6_start_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) || $fell(ras_n)) && $past(eng_idle) |-> $past(grant && !page_open));

endmodule

// File: tb/dram_refresh_sched_tb.sv
// Directed bench for the DRAM refresh scheduler.
module dram_refresh_sched_tb;
    localparam int RB       = 3;
    localparam int PAUSE    = 50;
    localparam int INTERVAL = 100;
    localparam int IDLE_LIM = 400;
    localparam int POSTPONE = 4;
    localparam int LEAD     = 1;
    localparam int RLOW     = 5;
    localparam int PRE      = 3;
    localparam int SRMIN    = 20;
    localparam int SRPRE    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_only_mode = 1'b0;
    logic          page_open = 1'b0;
    logic          grant = 1'b0;
    logic          selfref_req = 1'b0;
    logic          ref_req, ready, ras_n, cas_n;
    logic [RB-1:0] row_addr;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .ROW_BITS (RB), .PAUSE_CYC (PAUSE), .INIT_CYCLES (8),
        .REF_INTERVAL_CYC (INTERVAL), .IDLE_LIMIT_CYC (IDLE_LIM),
        .MAX_POSTPONE (POSTPONE), .CBR_LEAD_CYC (LEAD), .RAS_LOW_CYC (RLOW),
        .PRECH_CYC (PRE), .SR_MIN_CYC (SRMIN), .SR_PRECH_CYC (SRPRE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .ras_only_mode (ras_only_mode),
        .page_open (page_open), .grant (grant), .selfref_req (selfref_req),
        .ref_req (ref_req), .ready (ready), .ras_n (ras_n), .cas_n (cas_n),
        .row_addr (row_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Pin monitor: pulse counts, widths, strobe order, row sequence
    logic prev_r = 1'b1, prev_c = 1'b1;
    int   low_len = 0, high_len = 1000, lead = 0, last_low = 0, max_low = 0;
    int   pulse_cnt = 0, cbr_cnt = 0, ro_cnt = 0, prev_row = 0;
    bit   have_row = 0, wrap_seen = 0, cur_ro = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_r && !ras_n) begin
                pulse_cnt++;
                chk(page_open == 1'b0 && grant == 1'b1, "R6", int'(page_open), 0);
                if (last_low >= SRMIN) chk(high_len >= SRPRE, "R9", high_len, SRPRE);
                else                   chk(high_len >= PRE, "R3", high_len, PRE);
                if (!cas_n) begin
                    cbr_cnt++;
                    cur_ro = 0;
                    chk(lead >= LEAD, "R3", lead, LEAD);
                end else begin
                    ro_cnt++;
                    cur_ro = 1;
                    if (have_row) begin
                        chk(int'(row_addr) == ((prev_row + 1) % (1 << RB)), "R7",
                            int'(row_addr), (prev_row + 1) % (1 << RB));
                        if (prev_row == (1 << RB) - 1 && row_addr == '0) wrap_seen = 1;
                    end
                    prev_row = int'(row_addr);
                    have_row = 1;
                end
                high_len = 0;
                low_len  = 1;
            end else if (!prev_r && ras_n) begin
                chk(low_len >= RLOW, "R3", low_len, RLOW);
                last_low = low_len;
                if (low_len > max_low) max_low = low_len;
                low_len  = 0;
                high_len = 1;
            end else if (!ras_n) begin
                low_len++;
                if (cur_ro && !cas_n)           chk(0, "R7", 0, 1);
                if (!cur_ro && cas_n && !prev_c) chk(0, "R3", 1, 0);
                if (ready)                       chk(0, "R6", 1, 0);
            end else begin
                high_len++;
            end
            if (ras_n && !cas_n) lead++;
            else                 lead = 0;
            prev_r = ras_n;
            prev_c = cas_n;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 60000);
            summary();
        end
    end

    task automatic wait_ready(input int lim, input string req);
        @(negedge clk);
        for (int i = 0; i < lim; i++) begin
            if (ready) break;
            @(negedge clk);
        end
        chk(ready == 1'b1, req, int'(ready), 1);
    endtask

    // R10: reset values
    task automatic t_reset();
        repeat (5) @(negedge clk);
        chk(ras_n == 1'b1 && cas_n == 1'b1, "R10", int'({ras_n, cas_n}), 3);
        chk(ready == 1'b0 && ref_req == 1'b0, "R10", int'({ready, ref_req}), 0);
        chk(row_addr == '0, "R10", int'(row_addr), 0);
        grant = 1'b1;
        rst_n = 1'b1;
    endtask

    // R1: silent pause even with the pins offered
    task automatic t_pause();
        repeat (PAUSE - 5) @(negedge clk);
        chk(pulse_cnt == 0, "R1", pulse_cnt, 0);
        chk(ref_req == 1'b0 && ready == 1'b0, "R1", int'({ref_req, ready}), 0);
    endtask

    // R2: wake-up cycles in counter style
    task automatic t_init();
        wait_ready(400, "R2");
        chk(pulse_cnt == 8, "R2", pulse_cnt, 8);
        chk(cbr_cnt == 8, "R2", cbr_cnt, 8);
    endtask

    // R4: periodic refresh with the page closed
    task automatic t_periodic();
        int base;
        base = pulse_cnt;
        repeat (10 * INTERVAL) @(negedge clk);
        chk(pulse_cnt - base >= 9 && pulse_cnt - base <= 11, "R4", pulse_cnt - base, 10);
    endtask

    // R5: demands held while the page is open, capped, then flushed
    task automatic t_postpone();
        int base;
        wait_ready(50, "R5");
        page_open = 1'b1;
        base = pulse_cnt;
        repeat (7 * INTERVAL + 50) @(negedge clk);
        chk(pulse_cnt == base, "R5", pulse_cnt - base, 0);
        chk(ref_req == 1'b1 && ready == 1'b0, "R6", int'({ref_req, ready}), 2);
        page_open = 1'b0;
        wait_ready(200, "R5");
        chk(pulse_cnt - base == POSTPONE || pulse_cnt - base == POSTPONE + 1, "R5",
            pulse_cnt - base, POSTPONE);
    endtask

    // R9: long request tracks the request, short request holds the minimum
    task automatic t_selfref();
        wait_ready(50, "R9");
        max_low = 0;
        selfref_req = 1'b1;
        repeat (60) @(negedge clk);
        selfref_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(max_low >= 40 && max_low <= 60, "R9", max_low, 59);
        wait_ready(50, "R9");
        max_low = 0;
        selfref_req = 1'b1;
        for (int i = 0; i < 200; i++) begin
            if (!ras_n && low_len >= RLOW + 2) break;
            @(negedge clk);
        end
        selfref_req = 1'b0;
        repeat (60) @(negedge clk);
        chk(max_low == SRMIN, "R9", max_low, SRMIN);
    endtask

    // R7: row-address refresh, stepping and wrapping
    task automatic t_rasonly();
        int base;
        wait_ready(50, "R7");
        ras_only_mode = 1'b1;
        base = ro_cnt;
        repeat (11 * INTERVAL) @(negedge clk);
        chk(ro_cnt - base >= 9, "R7", ro_cnt - base, 10);
        chk(wrap_seen == 1'b1, "R7", int'(wrap_seen), 1);
    endtask

    // R8: idle stretch forces the wake-up cycles again (row-address style, R2)
    task automatic t_idle();
        int base, rbase;
        wait_ready(50, "R8");
        grant = 1'b0;
        base = pulse_cnt;
        repeat (IDLE_LIM + 50) @(negedge clk);
        chk(pulse_cnt == base, "R6", pulse_cnt - base, 0);
        chk(ready == 1'b0 && ref_req == 1'b1, "R8", int'({ready, ref_req}), 1);
        base  = pulse_cnt;
        rbase = ro_cnt;
        grant = 1'b1;
        wait_ready(300, "R8");
        chk(pulse_cnt - base == 8, "R8", pulse_cnt - base, 8);
        chk(ro_cnt - rbase == 8, "R2", ro_cnt - rbase, 8);
    endtask

    initial begin
        t_reset();
        t_pause();
        t_init();
        t_periodic();
        t_postpone();
        t_selfref();
        t_rasonly();
        t_idle();
        summary();
    end
endmodule